// File: doc/BRIEF.md
# Write-Intensity Tracking Table

This block is a small fully associative table that watches write hits to a cache and picks out addresses that are written again and again. Each slot keeps an address tag, a saturating hit count, a valid flag and a recency rank. A write hit to a tracked address bumps its count. A write hit to an untracked address claims a free slot, or when none is free it takes the slot touched longest ago. When a slot's count reaches the threshold, the block emits a one-cycle migration request that carries the address, so a cache controller can move that block into the fast-write region. The slot is then released.

An internal divider fires a decay event every `DECAY_PERIOD` cycles. On that event every tracked count drops by one, so addresses that stop being written leave the table. A combinational probe port reports in the same cycle whether an address is tracked. The same block, fed with read hits from the fast-write region instead of write hits, can serve as a read-intensity record that is probed before data are retired.

Top module: `wr_heat_table`

## Requirements
- R1: While reset is asserted and right after it is released, no slot is valid: `probe_hit` is 0 for every address and `mig_valid` is 0.
- R2: A record (`rec_valid`=1) of an address that is not tracked and stays below the threshold makes `probe_hit` report 1 for that address from the next cycle on. The new slot starts with a count of 1.
- R3: A record of a tracked address raises its count by one. When the count after a record reaches `THRESH`, `mig_valid` is 1 for exactly the following cycle and `mig_addr` equals the recorded address.
- R4: The slot that raised a migration request is released in the same edge. `probe_hit` for that address is 0 afterwards, and a new record of it restarts at a count of 1.
- R5: While any slot is free, a new address takes a free slot (the lowest-numbered one) and no tracked address is evicted.
- R6: When all slots are valid, a new address replaces the slot whose last record is the oldest. Every record, whether it matches or inserts, makes its slot the most recent.
- R7: At every `DECAY_PERIOD`-th clock edge after reset release, each valid slot's count drops by one, and a slot whose count reaches zero becomes invalid. The slot recorded at that same edge is exempt from that decay.
- R8: Cycles with `rec_valid`=0 and no decay event leave the table unchanged and never raise `mig_valid`. `probe_hit` depends only on the stored state and `probe_addr` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_valid | input | 1 | Record an access to `rec_addr` this cycle |
| rec_addr | input | ADDR_W | Address of the recorded access |
| probe_addr | input | ADDR_W | Address to look up |
| probe_hit | output | 1 | `probe_addr` is held in a valid slot (combinational) |
| mig_valid | output | 1 | One-cycle migration request |
| mig_addr | output | ADDR_W | Address for which migration is requested |

## Verification
The bench runs a four-slot, threshold-three configuration against an arithmetic model that tracks recency with timestamps rather than ranks. After every cycle it sweeps the probe across all addresses in use. It aims at several corner cases:
- Eviction once the table is full. A wrong victim choice shows up as a recently refreshed address vanishing from the probe.
- A free slot left behind by a migration or by decay. A design that evicts anyway, or reuses the wrong slot, loses a live address.
- A record that lands exactly on a decay edge. A design that decays the recorded slot too shows a count one short and a late migration request.
- Back-to-back records of an address right after its migration. A design that keeps the count would repeat the request.

// File: rtl/heat_pkg.sv
package heat_pkg;

  // Minimum index width of one bit, so a two-slot table still has an index.
  function automatic int unsigned idx_width(input int unsigned n);
    return (n < 3) ? 1 : $clog2(n);
  endfunction

  // Where the recorded access lands this cycle.
  typedef enum logic [1:0] {
    SEL_MATCH = 2'd0,
    SEL_FREE  = 2'd1,
    SEL_EVICT = 2'd2
  } slot_src_e;

endpackage

// File: rtl/heat_match.sv
module heat_match #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32
) (
  input  logic [ENTRIES-1:0][ADDR_W-1:0] tags,
  input  logic [ENTRIES-1:0]             valid,
  input  logic [ADDR_W-1:0]              key,
  output logic [ENTRIES-1:0]             hit_vec
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g] == key);
  end

endmodule

// File: rtl/heat_lru.sv
module heat_lru #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim_idx
);

  // Rank 0 is most recent; ranks stay a permutation of 0..ENTRIES-1.
  logic [ENTRIES-1:0][IDX_W-1:0] rank_q, rank_d;

  always_comb begin
    rank_d = rank_q;
    if (touch_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx) begin
          rank_d[i] = '0;
        end else if (rank_q[i] < rank_q[touch_idx]) begin
          rank_d[i] = rank_q[i] + IDX_W'(1);
        end
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rank_q[i] == IDX_W'(ENTRIES - 1)) victim_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) rank_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      rank_q <= rank_d;
    end
  end

endmodule

// File: rtl/wr_heat_table.sv
module wr_heat_table #(
  parameter int ENTRIES      = 16,
  parameter int ADDR_W       = 32,
  parameter int CNT_W        = 4,
  parameter int THRESH       = 8,
  parameter int DECAY_PERIOD = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_valid,
  input  logic [ADDR_W-1:0] rec_addr,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              probe_hit,
  output logic              mig_valid,
  output logic [ADDR_W-1:0] mig_addr
);
  import heat_pkg::*;

  localparam int IDX_W = int'(idx_width(ENTRIES));
  localparam int DIV_W = int'(idx_width(DECAY_PERIOD));
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_THR = CNT_W'(THRESH);

  logic [ENTRIES-1:0][ADDR_W-1:0] tag_q, tag_d;
  logic [ENTRIES-1:0][CNT_W-1:0]  cnt_q, cnt_d;
  logic [ENTRIES-1:0]             valid_q, valid_d;
  logic [DIV_W-1:0]               div_q, div_d;
  logic                           mig_valid_q, mig_valid_d;
  logic [ADDR_W-1:0]              mig_addr_q;

  logic [ENTRIES-1:0] wr_hit_vec, pr_hit_vec;
  logic [IDX_W-1:0]   hit_idx, free_idx, victim_idx, sel_idx;
  logic               any_free, decay_tick, reach_thr;
  logic [CNT_W-1:0]   base_cnt, new_cnt;
  slot_src_e          src;

  heat_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_wr_match (
    .tags(tag_q), .valid(valid_q), .key(rec_addr), .hit_vec(wr_hit_vec)
  );

  heat_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_pr_match (
    .tags(tag_q), .valid(valid_q), .key(probe_addr), .hit_vec(pr_hit_vec)
  );

  heat_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(rec_valid),
    .touch_idx(sel_idx), .victim_idx(victim_idx)
  );

  assign probe_hit = |pr_hit_vec;

  // Encode match and lowest free slot.
  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (wr_hit_vec[i]) hit_idx = IDX_W'(i);
      if (!valid_q[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  always_comb begin
    if (|wr_hit_vec)   src = SEL_MATCH;
    else if (any_free) src = SEL_FREE;
    else               src = SEL_EVICT;
    case (src)
      SEL_MATCH: sel_idx = hit_idx;
      SEL_FREE:  sel_idx = free_idx;
      default:   sel_idx = victim_idx;
    endcase
    base_cnt  = (src == SEL_MATCH) ? cnt_q[hit_idx] : '0;
    new_cnt   = (base_cnt == CNT_MAX) ? base_cnt : base_cnt + CNT_W'(1);
    reach_thr = (new_cnt >= CNT_THR);
  end

  assign decay_tick = (div_q == DIV_W'(DECAY_PERIOD - 1));
  assign div_d      = decay_tick ? '0 : div_q + DIV_W'(1);

  // Next state of the slots.
  always_comb begin
    tag_d   = tag_q;
    cnt_d   = cnt_q;
    valid_d = valid_q;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rec_valid && (IDX_W'(i) == sel_idx)) begin
        tag_d[i]   = rec_addr;
        cnt_d[i]   = reach_thr ? '0 : new_cnt;
        valid_d[i] = !reach_thr;
      end else if (decay_tick && valid_q[i]) begin
        cnt_d[i]   = cnt_q[i] - CNT_W'(1);
        valid_d[i] = (cnt_q[i] != CNT_W'(1));
      end
    end
    mig_valid_d = rec_valid && reach_thr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      valid_q     <= '0;
      div_q       <= '0;
      mig_valid_q <= 1'b0;
    end else begin
      cnt_q       <= cnt_d;
      valid_q     <= valid_d;
      div_q       <= div_d;
      mig_valid_q <= mig_valid_d;
    end
  end

  // Datapath registers without reset, written only under their enables.
  always_ff @(posedge clk) begin
    if (rec_valid) tag_q <= tag_d;
    if (mig_valid_d) mig_addr_q <= rec_addr;
  end

  assign mig_valid = mig_valid_q;
  assign mig_addr  = mig_addr_q;

endmodule

// File: rtl/wr_heat_table_chk.sv
module wr_heat_table_chk #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int THRESH  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rec_valid,
  input logic [ADDR_W-1:0]  rec_addr,
  input logic               mig_valid,
  input logic [ADDR_W-1:0]  mig_addr,
  input logic [ENTRIES-1:0] valid_vec
);

  // R3: a request only follows a record, and carries that record's address.
  a_r3_mig_after_record: assert property (@(posedge clk) disable iff (!rst_n)
    mig_valid |-> $past(rec_valid));

  a_r3_mig_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mig_valid |-> (mig_addr == $past(rec_addr)));

  // R8: no record, no request in the next cycle.
  a_r8_quiet_no_mig: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_valid |=> !mig_valid);

  // R8 / R7: without a record the number of valid slots cannot grow.
  a_r8_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_valid |=> ($countones(valid_vec) <= $past($countones(valid_vec))));

  // R2 / R5: one record adds at most one valid slot.
  a_r5_one_insert: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> ($countones(valid_vec) <= $past($countones(valid_vec)) + 1));

  // R4: a record of the just-migrated address restarts at one, so no repeat.
  if (THRESH > 1) begin : g_norepeat
    a_r4_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      (mig_valid && rec_valid && (rec_addr == mig_addr)) |=> !mig_valid);
  end

endmodule

bind wr_heat_table wr_heat_table_chk #(
  .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .THRESH(THRESH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_addr(rec_addr),
  .mig_valid(mig_valid), .mig_addr(mig_addr), .valid_vec(valid_q)
);

// File: tb/tb_wr_heat_table.sv
`timescale 1ns/100ps
module tb_wr_heat_table;
  localparam int P_ENT = 4;
  localparam int P_AW  = 8;
  localparam int P_CW  = 3;
  localparam int P_TH  = 3;
  localparam int P_DEC = 40;
  localparam int P_MAX = 7;
  localparam int SWEEP = 12;

  logic clk, rst_n, rec_valid, probe_hit, mig_valid;
  logic [P_AW-1:0] rec_addr, probe_addr, mig_addr;

  int checks = 0, errors = 0, edge_n = 0;
  int m_tag [P_ENT];
  int m_cnt [P_ENT];
  int m_st  [P_ENT];
  bit m_val [P_ENT];

  wr_heat_table #(.ENTRIES(P_ENT), .ADDR_W(P_AW), .CNT_W(P_CW),
                  .THRESH(P_TH), .DECAY_PERIOD(P_DEC)) dut (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_addr(rec_addr),
    .probe_addr(probe_addr), .probe_hit(probe_hit),
    .mig_valid(mig_valid), .mig_addr(mig_addr));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic bit m_has(input int a);
    for (int j = 0; j < P_ENT; j++) if (m_val[j] && m_tag[j] == a) return 1'b1;
    return 1'b0;
  endfunction

  task automatic probe_sweep(input string req);
    for (int a = 0; a < SWEEP; a++) begin
      probe_addr = P_AW'(a);
      #0.5;
      chk(probe_hit == m_has(a), req, int'(probe_hit), int'(m_has(a)));
    end
  endtask

  // One clock: model from the requirements, then compare outputs.
  task automatic do_cyc(input bit v, input int a, input string req);
    int sel, nc;
    bit tick, em;
    rec_valid = v;
    rec_addr  = P_AW'(a);
    @(posedge clk);
    edge_n++;
    sel = -1; em = 0; nc = 0;
    tick = (edge_n % P_DEC) == 0;
    if (v) begin
      for (int j = 0; j < P_ENT; j++) if (m_val[j] && m_tag[j] == a) sel = j;
      if (sel >= 0) begin
        nc = (m_cnt[sel] == P_MAX) ? P_MAX : m_cnt[sel] + 1;
      end else begin
        for (int j = P_ENT - 1; j >= 0; j--) if (!m_val[j]) sel = j;
        if (sel < 0) begin
          sel = 0;
          for (int j = 1; j < P_ENT; j++) if (m_st[j] < m_st[sel]) sel = j;
        end
        nc = 1;
      end
      m_tag[sel] = a;
      m_st[sel]  = edge_n;
      if (nc >= P_TH) begin
        em = 1; m_val[sel] = 0; m_cnt[sel] = 0;
      end else begin
        m_val[sel] = 1; m_cnt[sel] = nc;
      end
    end
    if (tick) begin
      for (int j = 0; j < P_ENT; j++) begin
        if (j != sel && m_val[j]) begin
          m_cnt[j]--;
          if (m_cnt[j] == 0) m_val[j] = 0;
        end
      end
    end
    #2;
    chk(mig_valid == em, req, int'(mig_valid), int'(em));
    if (em) chk(mig_addr == P_AW'(a), req, int'(mig_addr), a);
    probe_sweep(req);
    @(negedge clk);
    rec_valid = 1'b0;
  endtask

  initial begin
    bit [15:0] lfsr;
    rst_n = 1'b0; rec_valid = 1'b0; rec_addr = '0; probe_addr = '0;
    for (int j = 0; j < P_ENT; j++) begin
      m_tag[j] = 0; m_cnt[j] = 0; m_st[j] = 0; m_val[j] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: table empty and no request while in reset
    chk(mig_valid == 1'b0, "R1", int'(mig_valid), 0);
    probe_sweep("R1");
    rst_n = 1'b1;
    edge_n = 0;
    do_cyc(0, 0, "R1");

    // R2 insert, R3 count up to the threshold, R4 release
    do_cyc(1, 1, "R2");
    do_cyc(1, 1, "R3");
    do_cyc(1, 1, "R3");
    do_cyc(1, 1, "R4");
    do_cyc(0, 0, "R8");

    // R5 fill free slots, R6 replace the oldest after a refresh
    do_cyc(1, 2, "R5");
    do_cyc(1, 3, "R5");
    do_cyc(1, 4, "R5");
    do_cyc(1, 2, "R6");
    do_cyc(1, 5, "R6");
    do_cyc(1, 6, "R6");
    do_cyc(1, 7, "R6");
    do_cyc(1, 2, "R6");
    do_cyc(1, 8, "R6");

    // R8 idle cycles leave the table as it is
    repeat (3) do_cyc(0, 0, "R8");

    // R7 decay, with a record landing exactly on the decay edge
    while (((edge_n + 1) % P_DEC) != 0) do_cyc(0, 0, "R7");
    do_cyc(1, 8, "R7");
    repeat (P_DEC + 2) do_cyc(0, 0, "R7");
    do_cyc(1, 9, "R7");
    do_cyc(1, 9, "R7");
    repeat (P_DEC) do_cyc(0, 0, "R7");

    // R3 / R6 / R7 mixed traffic over a small address set
    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      do_cyc(lfsr[5:4] != 2'b00, (int'(lfsr[3:0]) % 9) + 1, "R3");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule